// File: doc/BRIEF.md
# Byte-Lane Masked Vector Expand

This unit spreads the low-order elements of a 128-bit source vector across the lanes selected by a 16-bit mask. The vector has sixteen byte lanes. Mask bit k belongs to lane k, and lane 0 sits at bits 7:0. Reading the mask upward from lane 0, the first set bit receives source lane 0, the next set bit receives source lane 1, and so on. Every lane whose mask bit is clear outputs zero.

Inside the unit, each mask bit is widened to a byte count of 0 or 1. The counts are summed across lanes with a logarithmic inclusive prefix sum, using shifts of 1, 2, 4 and then 8 lanes. The sums of inactive lanes are then cleared, and one is subtracted from every lane. An active lane therefore holds the gather index (count − 1), and an inactive lane holds 0xFF. A table lookup then picks one source byte per lane, and any index of 16 or more selects zero.

Operands arrive on a valid/ready port. The result leaves from an output register with its own valid flag, one cycle after the operands are accepted. While the downstream side keeps ready high, the unit accepts a new operation on every cycle.

Top module: `vexp_unit`

## Requirements
- R1: Numbering lanes from 0 at bits 7:0, the n-th lane whose mask bit is set (counting from lane 0 upward, n starting at 0) outputs source lane n. For example, mask pattern 1,1,0,0 repeated from lane 0 with source bytes a..p gives a,b,0,0,c,d,0,0,e,f,0,0,g,h,0,0.
- R2: Every lane whose mask bit is 0 outputs 0x00, whatever the source holds.
- R3: A mask of all zeros yields a result of all zeros.
- R4: A mask of all ones yields the source vector unchanged.
- R5: An operation is accepted on a cycle where in_valid and in_ready are both 1. On the next cycle out_valid is 1 and carries that operation's result. in_ready is 1 whenever out_valid is 0 or out_ready is 1.
- R6: While out_valid is 1 and out_ready is 0, out_valid and out_data hold their values.
- R7: During synchronous reset and in the cycle after it, out_valid is 0.
- R8: With out_ready held at 1, operations presented on consecutive cycles are all accepted, one per cycle, and their results come out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Unit can take operands this cycle |
| in_src | input | 128 | Source vector, lane k at bits 8k+7:8k |
| in_mask | input | 16 | Lane mask, bit k selects lane k |
| out_valid | output | 1 | Result register holds a valid result |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 128 | Expanded result vector |

## Verification
Backpressure is the hardest case to reach from the ports. The unit must hold a result while a new operand is waiting and in_ready is low, and then release both in order once out_ready returns. The random phase drops out_ready on about a third of cycles while in_valid stays mostly high, so it produces stall runs of several cycles with queued operands. A scoreboard checks that no result is lost, duplicated or reordered. Directed masks with a single set bit at lane 0 and at lane 15 test the extreme prefix counts: index 0 lands in the top lane, and the full count of 16 lands in the top lane when all bits are set.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  localparam int VEXP_LANES  = 16;
  localparam int VEXP_LANE_W = 8;
endpackage

// File: rtl/vexp_prefix.sv
module vexp_prefix #(
  parameter int LANES  = vexp_pkg::VEXP_LANES,
  parameter int LANE_W = vexp_pkg::VEXP_LANE_W
) (
  input  logic [LANES-1:0]             mask,
  output logic [LANES-1:0][LANE_W-1:0] idx
);
  localparam int STEPS = $clog2(LANES);

  logic [LANES-1:0][LANE_W-1:0] cnt [0:STEPS];

  // widen each mask bit into a lane count of 0 or 1
  for (genvar i = 0; i < LANES; i++) begin : g_widen
    assign cnt[0][i] = LANE_W'(mask[i]);
  end

  // log-step inclusive prefix sum, shifting toward higher lanes
  for (genvar s = 0; s < STEPS; s++) begin : g_step
    localparam int SH = 1 << s;
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i >= SH) begin : g_add
        assign cnt[s+1][i] = cnt[s][i] + cnt[s][i-SH];
      end else begin : g_keep
        assign cnt[s+1][i] = cnt[s][i];
      end
    end
  end

  // clear inactive lanes, then subtract one (inactive becomes all ones)
  for (genvar i = 0; i < LANES; i++) begin : g_idx
    logic [LANE_W-1:0] kept;
    assign kept   = mask[i] ? cnt[STEPS][i] : '0;
    assign idx[i] = kept - LANE_W'(1);
  end
endmodule

// File: rtl/vexp_lookup.sv
module vexp_lookup #(
  parameter int LANES  = vexp_pkg::VEXP_LANES,
  parameter int LANE_W = vexp_pkg::VEXP_LANE_W
) (
  input  logic [LANES-1:0][LANE_W-1:0] src,
  input  logic [LANES-1:0][LANE_W-1:0] idx,
  output logic [LANES-1:0][LANE_W-1:0] res
);
  // an index that matches no lane (16 or above) leaves the lane at zero
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      res[i] = '0;
      for (int j = 0; j < LANES; j++) begin
        if (idx[i] == LANE_W'(j)) res[i] = src[j];
      end
    end
  end
endmodule

// File: rtl/vexp_unit.sv
module vexp_unit #(
  parameter int LANES  = vexp_pkg::VEXP_LANES,
  parameter int LANE_W = vexp_pkg::VEXP_LANE_W,
  localparam int VW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VW-1:0]    in_src,
  input  logic [LANES-1:0] in_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VW-1:0]    out_data
);
  logic [LANES-1:0][LANE_W-1:0] src_lanes;
  logic [LANES-1:0][LANE_W-1:0] gidx;
  logic [LANES-1:0][LANE_W-1:0] expd;
  logic                         accept;

  assign src_lanes = in_src;

  vexp_prefix #(.LANES(LANES), .LANE_W(LANE_W)) u_prefix (
    .mask (in_mask),
    .idx  (gidx)
  );

  vexp_lookup #(.LANES(LANES), .LANE_W(LANE_W)) u_lookup (
    .src (src_lanes),
    .idx (gidx),
    .res (expd)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) out_data <= expd;
  end

  // lookup output against the mask that fed the index path
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_inactive_zero_R2: assert property (@(posedge clk) disable iff (rst)
      !in_mask[i] |-> (expd[i] == '0));
  end

  assert_zero_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (in_mask == '0) |-> (expd == '0));

  assert_full_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (&in_mask) |-> (expd == src_lanes));

  assert_accept_valid_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/tb_vexp_unit.sv
module tb_vexp_unit;
  localparam int LANES = 16;
  localparam int LW    = 8;
  localparam int VW    = LANES * LW;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic             in_ready;
  logic [VW-1:0]    in_src;
  logic [LANES-1:0] in_mask;
  logic             out_valid;
  logic             out_ready;
  logic [VW-1:0]    out_data;

  int checks = 0;
  int errors = 0;
  logic [VW-1:0] expq [$];
  logic [VW-1:0] held;
  logic          was_stalled = 1'b0;
  logic          prev_accept = 1'b0;

  always #4 clk = ~clk;

  vexp_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_mask(in_mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [VW-1:0] ref_expand(logic [VW-1:0] s, logic [LANES-1:0] m);
    logic [VW-1:0] r = '0;
    int n = 0;
    for (int k = 0; k < LANES; k++) begin
      if (m[k]) begin
        r[k*LW +: LW] = s[n*LW +: LW];
        n++;
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, then observe, then let the rising edge act
  task automatic step(input logic v, input logic [VW-1:0] s, input logic [LANES-1:0] m,
                      input logic rdy, input string req);
    @(negedge clk);
    if (was_stalled) check("R6", out_data, held);
    if (prev_accept) check("R5", {127'd0, out_valid}, {127'd0, 1'b1});
    in_valid = v; in_src = s; in_mask = m; out_ready = rdy;
    #1;
    check("R5", {127'd0, in_ready}, {127'd0, (!out_valid || out_ready)});
    if (out_valid && out_ready) begin
      if (expq.size() == 0) check(req, out_data, 'x);
      else check(req, out_data, expq.pop_front());
    end
    was_stalled = out_valid && !out_ready;
    held = out_data;
    prev_accept = v && in_ready;
    if (prev_accept) expq.push_back(ref_expand(s, m));
  endtask

  task automatic drain(string req);
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, 1'b1, req);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [VW-1:0] abc;
    logic [LANES-1:0] m;
    logic [VW-1:0] s;
    int seed;
    seed = $urandom(32'd20250922);
    rst = 1'b1; in_valid = 1'b0; in_src = '0; in_mask = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", {127'd0, out_valid}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R7", {127'd0, out_valid}, '0);

    for (int k = 0; k < LANES; k++) abc[k*LW +: LW] = 8'h61 + 8'(k);
    // R1 check vector: 1,1,0,0 repeated from lane 0
    step(1'b1, abc, 16'h3333, 1'b1, "R1");
    drain("R1");
    check("R1", out_data, {8'h0,8'h0,8'h68,8'h67,8'h0,8'h0,8'h66,8'h65,
                           8'h0,8'h0,8'h64,8'h63,8'h0,8'h0,8'h62,8'h61});
    step(1'b1, abc, 16'h0000, 1'b1, "R3");
    step(1'b1, abc, 16'hFFFF, 1'b1, "R4");
    step(1'b1, abc, 16'h8000, 1'b1, "R1");
    step(1'b1, abc, 16'h0001, 1'b1, "R2");
    step(1'b1, {VW{1'b1}}, 16'h5A5A, 1'b1, "R2");
    drain("R4");

    // R8: back-to-back with ready high
    for (int k = 0; k < 20; k++) begin
      s = {$urandom, $urandom, $urandom, $urandom};
      step(1'b1, s, 16'($urandom), 1'b1, "R8");
      check("R8", {127'd0, in_ready}, {127'd0, 1'b1});
    end
    drain("R8");

    // random with backpressure
    for (int k = 0; k < 3000; k++) begin
      s = {$urandom, $urandom, $urandom, $urandom};
      m = 16'($urandom);
      if ($urandom % 8 == 0) m = '0;
      if ($urandom % 8 == 1) m = '1;
      step(($urandom % 5) != 0, s, m, ($urandom % 3) != 0, "R1");
    end
    drain("R1");
    check("R8", {127'd0, ($unsigned(expq.size()) == 0)}, {127'd0, 1'b1});

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7", {127'd0, out_valid}, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule